// File: doc/BRIEF.md
# Dual-Width Memory Read Port

This block models the read side of a non-volatile memory whose organisation is chosen at run time. With the width-select input high it returns a full 16-bit word per address. With it low it returns one byte per access on the low eight bus lines. In byte organisation the top bus line stops carrying data and becomes an extra address bit below the lowest word-address bit, choosing which half of the stored word appears. The stored contents live in a small register array that a side port fills before use.

Two active-low controls gate the bus. A chip select puts the port in standby whenever it is high, and an output enable decides whether a selected port actually drives. Only the pair low together produces data. When a high-voltage flag is raised on address line 9, an identification mode replaces array data with two fixed codes chosen by address line 0. Any other address line held high in that mode raises an error flag. All outputs are registered, so a result appears one clock after its inputs are sampled. The tri-state bus is represented by a data vector plus a per-bit drive-enable vector.

Top module: `dual_width_rom_port`

## Requirements
- R1: While reset is low, and in the first cycle after it, `dq_oe` is all zero and `id_illegal` is 0.
- R2: With `word_mode`=1 and `ce_n`=`oe_n`=0 and `id_hv`=0, one cycle later `dq_oe`=16'hFFFF and `dq_out` equals the stored word at `addr`.
- R3: With `word_mode`=0 and both enables low, one cycle later `dq_oe`=16'h00FF and `dq_out[7:0]` is the stored word's bits 7..0 when `dq15_in`=0 and its bits 15..8 when `dq15_in`=1. Bits 15..8 of the bus are undriven.
- R4: With `ce_n`=0 and `oe_n`=1, the next cycle has `dq_oe` all zero.
- R5: With `ce_n`=1, the next cycle has `dq_oe` all zero whatever `oe_n`, `word_mode` or `id_hv` are.
- R6: With `id_hv`=1 and both enables low, one cycle later `dq_out[7:0]` is 8'h20 when `addr[0]`=0 and 8'hB1 when `addr[0]`=1. In word mode `dq_out[15:8]` is driven as zero. In byte mode `dq15_in` has no effect.
- R7: `id_illegal` is 1 in the cycle after a sample where `ce_n`=0, `id_hv`=1 and any `addr` bit other than 0 and 9 is 1. It is 0 after every other sample.
- R8: A change of `word_mode` appears in the cycle after it is sampled. On a switch into byte mode, bits 15..8 become undriven in the same cycle that the selected byte first appears.
- R9: A write on the side port (`load_en`=1) stores `load_data` at `load_addr`. A read of that same address in the same cycle returns the previous contents, and later reads return the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | Word address; bit 0 also selects the identification code |
| id_hv | input | 1 | High-voltage flag on address line 9, enters identification mode |
| dq15_in | input | 1 | Value seen on the top bus line; low byte-address bit in byte mode |
| ce_n | input | 1 | Chip select, active low; high means standby |
| oe_n | input | 1 | Output enable, active low |
| word_mode | input | 1 | 1 selects 16-bit organisation, 0 selects 8-bit |
| load_en | input | 1 | Side-port write strobe |
| load_addr | input | ADDR_W | Side-port write address |
| load_data | input | DATA_W | Side-port write data |
| dq_out | output | DATA_W | Registered bus data |
| dq_oe | output | DATA_W | Per-bit drive enable for the bus |
| id_illegal | output | 1 | Registered flag for an illegal address in identification mode |

## Verification
Two functions can meet in one cycle: a side-port write and a read of the same word. The bench schedules the write on the address being read and checks that the old contents come out, then reads the same address again and expects the new word. A second overlap is a width switch alongside the half-select bit. In one cycle `word_mode` drops and `dq15_in` rises, and the bench judges that the upper byte arrives on bits 7..0 while bits 15..8 stop driving. A cycle-accurate model in the bench produces every expected value.

// File: rtl/dual_width_rom_port.sv
module dual_width_rom_port #(
  parameter int          ADDR_W   = 10,
  parameter int          DATA_W   = 16,
  parameter int          ID_LINE  = 9,
  parameter logic [7:0]  MFR_CODE = 8'h20,
  parameter logic [7:0]  DEV_CODE = 8'hB1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              id_hv,
  input  logic              dq15_in,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              word_mode,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] dq_oe,
  output logic              id_illegal
);
  localparam int HALF  = DATA_W / 2;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] KEEP = ADDR_W'(1) | (ADDR_W'(1) << ID_LINE);
  localparam logic [DATA_W-1:0] LOW_OE = {{HALF{1'b0}}, {HALF{1'b1}}};

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk)
    if (load_en) mem[load_addr] <= load_data;

  wire              selected = !ce_n && !oe_n;
  wire [DATA_W-1:0] word     = mem[addr];
  wire [HALF-1:0]   code     = addr[0] ? DEV_CODE[HALF-1:0] : MFR_CODE[HALF-1:0];
  wire [HALF-1:0]   half     = dq15_in ? word[DATA_W-1:HALF] : word[HALF-1:0];
  wire              bad      = !ce_n && id_hv && |(addr & ~KEEP);

  logic [DATA_W-1:0] nxt_data, nxt_oe;

  always_comb begin
    nxt_oe   = '0;
    nxt_data = '0;
    if (selected) begin
      nxt_oe = word_mode ? '1 : LOW_OE;
      if (id_hv)          nxt_data = {{HALF{1'b0}}, code};
      else if (word_mode) nxt_data = word;
      else                nxt_data = {{HALF{1'b0}}, half};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dq_out     <= '0;
      dq_oe      <= '0;
      id_illegal <= 1'b0;
    end else begin
      dq_out     <= nxt_data;
      dq_oe      <= nxt_oe;
      id_illegal <= bad;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (dq_oe == '0 && !id_illegal));

  assert_oe_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe == '0 || dq_oe == '1 || dq_oe == LOW_OE));

  assert_byte_upper_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(word_mode)) |-> (dq_oe[DATA_W-1:HALF] == '0));

  assert_enable_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(oe_n) || $past(ce_n)) |-> (dq_oe == '0));

  assert_id_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(id_hv) && !$past(ce_n) && !$past(oe_n))
      |-> (dq_out[HALF-1:0] == ($past(addr[0]) ? DEV_CODE[HALF-1:0] : MFR_CODE[HALF-1:0])));

  assert_illegal_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    id_illegal |-> ($past(id_hv) && !$past(ce_n)));

  assert_mode_switch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $fell(dq_oe[DATA_W-1]) && dq_oe[0]) |-> !$past(word_mode));
endmodule

// File: tb/sim_dual_width_rom_port.sv
`timescale 1ns/1ps
module sim_dual_width_rom_port;
  localparam int AW = 10;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          id_hv = 1'b0, dq15_in = 1'b0, ce_n = 1'b1, oe_n = 1'b1, word_mode = 1'b1;
  logic          load_en = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic [DW-1:0] load_data = '0;
  logic [DW-1:0] dq_out, dq_oe;
  logic          id_illegal;

  int applied = 0, wrong = 0;
  bit finished = 0;
  logic [DW-1:0] model [0:(1<<AW)-1];

  always #2 clk = ~clk;

  dual_width_rom_port u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .id_hv(id_hv), .dq15_in(dq15_in),
    .ce_n(ce_n), .oe_n(oe_n), .word_mode(word_mode), .load_en(load_en),
    .load_addr(load_addr), .load_data(load_data),
    .dq_out(dq_out), .dq_oe(dq_oe), .id_illegal(id_illegal));

  task automatic cyc(input string tag);
    logic [DW-1:0] e_oe, e_out;
    logic          e_ill;
    logic [DW-1:0] w;
    @(posedge clk);
    e_oe = '0; e_out = '0; e_ill = 1'b0;
    w = model[addr];
    if (rst_n) begin
      if (!ce_n && id_hv) begin
        for (int b = 1; b < AW; b++)
          if (b != 9 && addr[b]) e_ill = 1'b1;
      end
      if (!ce_n && !oe_n) begin
        e_oe = word_mode ? 16'hFFFF : 16'h00FF;
        if (id_hv) e_out = addr[0] ? 16'h00B1 : 16'h0020;
        else if (word_mode) e_out = w;
        else e_out = dq15_in ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
      end
    end
    if (load_en) model[load_addr] = load_data;
    @(negedge clk);
    applied++;
    if (dq_oe !== e_oe || (dq_out & e_oe) !== (e_out & e_oe) || id_illegal !== e_ill) begin
      wrong++;
      $display("FAIL %s: oe=%h out=%h ill=%b expected oe=%h out=%h ill=%b",
               tag, dq_oe, dq_out & dq_oe, id_illegal, e_oe, e_out & e_oe, e_ill);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic wm, input logic hb, input string tag);
    addr = a; word_mode = wm; dq15_in = hb; ce_n = 0; oe_n = 0; id_hv = 0;
    cyc(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      wrong++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, wrong);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1<<AW); i++) model[i] = 'x;
    @(negedge clk);
    ce_n = 0; oe_n = 0;
    repeat (3) cyc("R1 reset");
    rst_n = 1; ce_n = 1;
    cyc("R1 first cycle");
    // Preload: oe_n low while ce_n high, standby must hold (R5)
    oe_n = 0;
    for (int i = 0; i < (1<<AW); i++) begin
      load_en = 1; load_addr = AW'(i); load_data = DW'((i * 40503) ^ 16'h5A5A);
      addr = AW'(i); id_hv = i[0]; word_mode = i[1];
      cyc("R5 standby during preload");
    end
    load_en = 0;
    // Word reads R2
    for (int i = 0; i < 40; i++) rd(AW'(i * 37 + 5), 1, i[0], "R2 word read");
    // Byte reads R3
    for (int i = 0; i < 40; i++) rd(AW'(i * 53 + 11), 0, i[0], "R3 byte read");
    // R4 output enable high
    addr = 10'h155; ce_n = 0; oe_n = 1; word_mode = 1; cyc("R4 oe_n high word");
    word_mode = 0; cyc("R4 oe_n high byte");
    // R5 chip select high
    ce_n = 1; oe_n = 0; id_hv = 1; cyc("R5 standby with id");
    id_hv = 0; word_mode = 1; cyc("R5 standby word");
    // R8 mode switching, with half select in the same cycle
    rd(10'h0A3, 1, 0, "R8 word before switch");
    rd(10'h0A3, 0, 1, "R8 switch into byte upper half");
    rd(10'h0A3, 0, 0, "R8 byte lower half");
    rd(10'h0A3, 1, 1, "R8 switch back to word");
    rd(10'h0A3, 0, 0, "R8 switch into byte again");
    // R6 identification codes
    for (int m = 0; m < 2; m++)
      for (int a0 = 0; a0 < 2; a0++) begin
        addr = AW'(a0); id_hv = 1; word_mode = m[0]; ce_n = 0; oe_n = 0; dq15_in = 0;
        cyc("R6 id code");
        dq15_in = 1; cyc("R6 id code, dq15_in ignored");
      end
    addr = 10'h201; cyc("R6 id with addr9 set");
    // R7 illegal access
    addr = 10'h004; cyc("R7 illegal addr bit 2");
    addr = 10'h101; oe_n = 1; cyc("R7 illegal with oe_n high");
    ce_n = 1; cyc("R7 no flag in standby");
    ce_n = 0; oe_n = 0; addr = 10'h001; cyc("R7 legal id clears flag");
    addr = 10'h3FF; id_hv = 0; cyc("R7 no flag without id");
    // R9 write/read collision
    addr = 10'h077; word_mode = 1; load_en = 1; load_addr = 10'h077; load_data = 16'hC3E1;
    cyc("R9 same-cycle write returns old data");
    load_en = 0;
    cyc("R9 new data after write");
    load_en = 1; load_addr = 10'h078; load_data = 16'h1234; addr = 10'h078; word_mode = 0; dq15_in = 1;
    cyc("R9 byte collision old data");
    load_en = 0; cyc("R9 byte read new upper half");
    dq15_in = 0; cyc("R9 byte read new lower half");
    // back into reset mid-traffic
    rst_n = 0; cyc("R1 reset during read");
    rst_n = 1; cyc("R1 read resumes after reset");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, wrong);
    $finish;
  end
endmodule